// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block turns a virtual address into a physical address by looking up one entry in a flat page table that sits in an ordinary memory. A requester presents a virtual address and says whether the access is a read or a write. The low 12 bits (the byte offset inside a 4 KB page) pass straight through. The 20-bit virtual page number is bounds-checked against a limit register. If it is in range, it indexes the table. The table starts at a base address held in a second register, and each entry is one 32-bit word, so the entry sits at base + page number * 4.

The table entry is fetched over a synchronous read port with a fixed latency of one cycle. The block then checks the entry's present flag and its read or write permission, and returns exactly one outcome:
- a 24-bit physical address, or
- one of three fault codes.

Base and limit are process context. Privileged software rewrites them through a small configuration write port on each context switch.

Requests and responses use valid/ready handshakes. Only one translation is in flight at a time.

Top module: `pt_xlate`

## Requirements
- R1: After reset `reqReady`=1, `rspValid`=0 and `memRdEn`=0. The base register and the limit register are both 0, so only page number 0 is in range and its entry is read from address 0.
- R2: An accepted in-range request causes exactly one table read. `memRdEn` is high for one cycle, starting in the cycle after acceptance, with `memAddr` = base + page number * 4 (taken modulo 2^24). `rspValid` rises two cycles after that read cycle.
- R3: Entry layout, by bit position:
  - bit 0: present
  - bit 1: readable
  - bit 2: writable
  - bit 3: dirty
  - bits 23:12: frame number
  - all other bits: ignored

  On success `rspCode`=0 and `rspPaddr` = {frame number, virtual address bits 11:0}.
- R4: A page number greater than the limit register returns `rspCode`=1 (limit) and performs no table read. A page number equal to the limit is in range.
- R5: An entry with bit 0 clear returns `rspCode`=2 (page fault), whatever its permission bits hold.
- R6: A read (`reqWrite`=0) of an entry with bit 1 clear, or a write (`reqWrite`=1) to an entry with bit 2 clear, returns `rspCode`=3 (protection). The permission bit that does not apply to the access type has no effect.
- R7: Exactly one code is reported per request, with this priority:
  - limit (1) outranks page fault (2);
  - page fault (2) outranks protection (3).
- R8: `rspDirty` carries entry bit 3 on success. On any fault `rspPaddr`=0 and `rspDirty`=0.
- R9: While `rspValid`=1 and `rspReady`=0, the code, address and dirty outputs hold still. `reqReady` stays 0 from acceptance until the response is taken, and then returns to 1 in the next cycle.
- R10: A configuration write with `cfgSel`=0 loads the base from `cfgData` bits 23:0. With `cfgSel`=1 it loads the limit from `cfgData` bits 19:0. Higher bits are ignored, and the new value governs the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Privileged configuration write strobe |
| cfgSel | input | 1 | 0 selects the table base register, 1 selects the limit register |
| cfgData | input | 32 | Configuration write value |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Block can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| memRdEn | output | 1 | Table read strobe |
| memAddr | output | 24 | Byte address of the table entry |
| memRdData | input | 32 | Entry data, valid the cycle after `memRdEn` |
| rspValid | output | 1 | Translation result present |
| rspReady | input | 1 | Requester takes the result |
| rspCode | output | 2 | 0 ok, 1 limit, 2 page fault, 3 protection |
| rspPaddr | output | 24 | Physical address (0 on a fault) |
| rspDirty | output | 1 | Dirty flag of the translated page |

## Verification
The hardest case to reach from the ports is a fault whose correct code depends on the ordering between checks.

For limit faults, the real proof is that the memory port stayed idle. The bench's memory model therefore counts reads and records the last address, and every vector states whether a read is expected.

Entries that are absent but carry permission bits, and writes to entries that are readable only, are placed directly into the model memory to show the priority between page fault and protection. Reloading base and limit between requests covers the context-switch path.

// File: rtl/pt_xlate_pkg.sv
`timescale 1ns/1ps
package pt_xlate_pkg;

  typedef enum logic [1:0] {
    RC_OK    = 2'd0,
    RC_LIMIT = 2'd1,
    RC_PAGE  = 2'd2,
    RC_PROT  = 2'd3
  } rspCode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WAIT,
    ST_RESP
  } xlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureReq;
    logic issueRead;
    logic capturePte;
    logic flagLimit;
  } xlStrobe_t;

  // entry flag positions (R3)
  localparam int VLD_BIT   = 0;
  localparam int RD_BIT    = 1;
  localparam int WR_BIT    = 2;
  localparam int DIRTY_BIT = 3;

endpackage

// File: rtl/pt_xlate_ctrl.sv
`timescale 1ns/1ps
module pt_xlate_ctrl
  import pt_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      rspReady,
  input  logic      limitExceeded,
  output logic      reqReady,
  output logic      rspValid,
  output logic      memRdEn,
  output xlStrobe_t strb
);

  xlState_e state;
  xlState_e stateNxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    strb     = '0;
    stateNxt = state;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strb.captureReq = 1'b1;
          stateNxt        = ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        // bounds are settled before any table access
        if (limitExceeded) begin
          strb.flagLimit = 1'b1;
          stateNxt       = ST_RESP;
        end else begin
          strb.issueRead = 1'b1;
          stateNxt       = ST_WAIT;
        end
      end
      ST_WAIT: begin
        strb.capturePte = 1'b1;
        stateNxt        = ST_RESP;
      end
      ST_RESP: begin
        if (rspReady) stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign rspValid = (state == ST_RESP);
  assign memRdEn  = strb.issueRead;

  // R2: a translation never issues two back-to-back reads
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> !memRdEn);

  // R9: after acceptance the block refuses further requests
  a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R9: a taken response frees the block in the next cycle
  a_r9_ready_returns: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspReady |=> reqReady && !rspValid);

endmodule

// File: rtl/pt_xlate_dp.sv
`timescale 1ns/1ps
module pt_xlate_dp
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [VA_W-1:0]   cfgData,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              reqWrite,
  input  logic [PTE_W-1:0]  memRdData,
  input  xlStrobe_t         strb,
  output logic              limitExceeded,
  output logic [PA_W-1:0]   memAddr,
  output rspCode_e          rspCode,
  output logic [PA_W-1:0]   rspPaddr,
  output logic              rspDirty
);

  localparam int VPN_W = VA_W - PAGE_BITS;
  localparam int PFN_W = PA_W - PAGE_BITS;
  localparam int IDX_W = VPN_W + 2;   // byte offset of a 4-byte entry

  logic [PA_W-1:0]      baseQ;
  logic [VPN_W-1:0]     limitQ;
  logic [VPN_W-1:0]     vpnQ;
  logic [PAGE_BITS-1:0] offQ;
  logic                 wrQ;
  rspCode_e             codeQ;
  logic [PA_W-1:0]      paddrQ;
  logic                 dirtyQ;

  // context registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      limitQ <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) limitQ <= cfgData[VPN_W-1:0];
      else        baseQ  <= cfgData[PA_W-1:0];
    end
  end

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ <= '0;
      offQ <= '0;
      wrQ  <= 1'b0;
    end else if (strb.captureReq) begin
      vpnQ <= reqVaddr[VA_W-1:PAGE_BITS];
      offQ <= reqVaddr[PAGE_BITS-1:0];
      wrQ  <= reqWrite;
    end
  end

  logic [IDX_W-1:0] entryOfs;
  assign entryOfs      = {vpnQ, 2'b00};
  assign memAddr       = baseQ + PA_W'(entryOfs);
  assign limitExceeded = (vpnQ > limitQ);

  // entry decode
  logic             ptePresent;
  logic             permOk;
  logic [PFN_W-1:0] ptePfn;
  assign ptePresent = memRdData[VLD_BIT];
  assign permOk     = wrQ ? memRdData[WR_BIT] : memRdData[RD_BIT];
  assign ptePfn     = memRdData[PAGE_BITS +: PFN_W];

  // result register, ordered by fault priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ  <= RC_OK;
      paddrQ <= '0;
      dirtyQ <= 1'b0;
    end else if (strb.flagLimit) begin
      codeQ  <= RC_LIMIT;
      paddrQ <= '0;
      dirtyQ <= 1'b0;
    end else if (strb.capturePte) begin
      if (!ptePresent) begin
        codeQ  <= RC_PAGE;
        paddrQ <= '0;
        dirtyQ <= 1'b0;
      end else if (!permOk) begin
        codeQ  <= RC_PROT;
        paddrQ <= '0;
        dirtyQ <= 1'b0;
      end else begin
        codeQ  <= RC_OK;
        paddrQ <= {ptePfn, offQ};
        dirtyQ <= memRdData[DIRTY_BIT];
      end
    end
  end

  assign rspCode  = codeQ;
  assign rspPaddr = paddrQ;
  assign rspDirty = dirtyQ;

  logic unusedBits;
  assign unusedBits = ^{memRdData[PTE_W-1:PA_W],
                        memRdData[PAGE_BITS-1:DIRTY_BIT+1],
                        cfgData[VA_W-1:PA_W]};

endmodule

// File: rtl/pt_xlate.sv
`timescale 1ns/1ps
module pt_xlate
  import pt_xlate_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int PA_W      = 24,
  parameter int PAGE_BITS = 12,
  parameter int PTE_W     = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [VA_W-1:0]  cfgData,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic             reqWrite,
  output logic             memRdEn,
  output logic [PA_W-1:0]  memAddr,
  input  logic [PTE_W-1:0] memRdData,
  output logic             rspValid,
  input  logic             rspReady,
  output logic [1:0]       rspCode,
  output logic [PA_W-1:0]  rspPaddr,
  output logic             rspDirty
);

  xlStrobe_t strb;
  logic      limitExceeded;
  rspCode_e  codeInt;

  pt_xlate_ctrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .rspReady      (rspReady),
    .limitExceeded (limitExceeded),
    .reqReady      (reqReady),
    .rspValid      (rspValid),
    .memRdEn       (memRdEn),
    .strb          (strb)
  );

  pt_xlate_dp #(
    .VA_W      (VA_W),
    .PA_W      (PA_W),
    .PAGE_BITS (PAGE_BITS),
    .PTE_W     (PTE_W)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .cfgWrEn       (cfgWrEn),
    .cfgSel        (cfgSel),
    .cfgData       (cfgData),
    .reqVaddr      (reqVaddr),
    .reqWrite      (reqWrite),
    .memRdData     (memRdData),
    .strb          (strb),
    .limitExceeded (limitExceeded),
    .memAddr       (memAddr),
    .rspCode       (codeInt),
    .rspPaddr      (rspPaddr),
    .rspDirty      (rspDirty)
  );

  assign rspCode = codeInt;

  // R9: a stalled response keeps every field
  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid && $stable(rspCode) &&
                              $stable(rspPaddr) && $stable(rspDirty));

  // R8: faults carry no address and no dirty flag
  a_r8_fault_clean: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && (rspCode != 2'd0) |-> (rspPaddr == '0) && !rspDirty);

  // R4: a limit result is not preceded by a table read
  a_r4_limit_no_read: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) && (rspCode == 2'd1) |-> !$past(memRdEn));

  // R2: every other result follows a read two cycles earlier
  a_r2_read_before_result: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rspValid) && (rspCode != 2'd1) |-> $past(memRdEn, 2));

endmodule

// File: tb/pt_xlate_tb.sv
`timescale 1ns/1ps
module pt_xlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        memRdEn;
  logic [23:0] memAddr;
  logic [31:0] memRdData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [1:0]  rspCode;
  logic [23:0] rspPaddr;
  logic        rspDirty;

  int total = 0;
  int bad = 0;
  int readCnt = 0;
  logic [23:0] lastAddr = '0;
  logic [31:0] mem [64];

  always #10 clk = ~clk;   // 50 MHz

  pt_xlate u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .rspValid(rspValid), .rspReady(rspReady), .rspCode(rspCode),
    .rspPaddr(rspPaddr), .rspDirty(rspDirty)
  );

  // memory model: one-cycle read latency, word index from address bits 7:2
  always @(posedge clk) begin
    if (rstN && memRdEn) begin
      memRdData <= mem[memAddr[7:2]];
      lastAddr  <= memAddr;
      readCnt   <= readCnt + 1;
    end
  end

  typedef struct packed {
    logic [19:0] vpn;
    logic [11:0] off;
    logic        wr;
    logic [31:0] pte;
    logic [1:0]  code;
    logic [23:0] paddr;
    logic        dirty;
    logic        rd;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 11;
  // base 0x000100, limit 20
  localparam vec_t VECS [NV] = '{
    '{20'h00001, 12'h234, 1'b0, 32'h00ABC003, 2'd0, 24'hABC234, 1'b0, 1'b1, 4'd3},  // R3 read ok
    '{20'h00002, 12'hFFF, 1'b1, 32'h0012300D, 2'd0, 24'h123FFF, 1'b1, 1'b1, 4'd6},  // R6 write ok, read bit clear; R8 dirty
    '{20'h00003, 12'h010, 1'b0, 32'h00555006, 2'd2, 24'h000000, 1'b0, 1'b1, 4'd5},  // R5 absent with perms
    '{20'h00004, 12'h000, 1'b0, 32'h00777005, 2'd3, 24'h000000, 1'b0, 1'b1, 4'd6},  // R6 read no-read
    '{20'h00005, 12'h001, 1'b1, 32'h00777003, 2'd3, 24'h000000, 1'b0, 1'b1, 4'd6},  // R6 write no-write
    '{20'h00014, 12'h000, 1'b0, 32'h00FFF003, 2'd0, 24'hFFF000, 1'b0, 1'b1, 4'd4},  // R4 vpn == limit
    '{20'h00015, 12'h5A5, 1'b0, 32'h00111003, 2'd1, 24'h000000, 1'b0, 1'b0, 4'd4},  // R4 vpn > limit
    '{20'hFFFFF, 12'h000, 1'b1, 32'h00000000, 2'd1, 24'h000000, 1'b0, 1'b0, 4'd7},  // R7 limit over page fault
    '{20'h00006, 12'h000, 1'b1, 32'h00222002, 2'd2, 24'h000000, 1'b0, 1'b1, 4'd7},  // R7 page over protection
    '{20'h00007, 12'h010, 1'b0, 32'hFF9A5FFB, 2'd0, 24'h9A5010, 1'b1, 1'b1, 4'd3},  // R3 ignored bits set
    '{20'h00008, 12'hABC, 1'b1, 32'h00FED007, 2'd0, 24'hFEDABC, 1'b0, 1'b1, 4'd8}   // R8 clean page
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic sel, input logic [31:0] val);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = val;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic doReq(input logic [19:0] vpn, input logic [11:0] off, input logic wr,
                       output logic [1:0] code, output logic [23:0] pa, output logic d,
                       output int nrd, output logic [23:0] addr);
    int r0;
    r0 = readCnt;
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {vpn, off}; reqWrite = wr;
    @(negedge clk);
    reqValid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (rspValid) break;
      @(negedge clk);
    end
    code = rspCode; pa = rspPaddr; d = rspDirty;
    nrd = readCnt - r0; addr = lastAddr;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0]  c;
    logic [23:0] pa;
    logic        d;
    int          nrd;
    logic [23:0] addr;

    for (int i = 0; i < 64; i++) mem[i] = '0;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 reqReady", {31'b0, reqReady}, 32'd1);
    chk("R1 rspValid", {31'b0, rspValid}, 32'd0);
    chk("R1 memRdEn", {31'b0, memRdEn}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 default base 0 and limit 0
    mem[0] = 32'h00042003;
    doReq(20'h0, 12'h008, 1'b0, c, pa, d, nrd, addr);
    chk("R1 vpn0 code", {30'b0, c}, 32'd0);
    chk("R1 vpn0 paddr", {8'b0, pa}, 32'h042008);
    chk("R1 vpn0 read addr", {8'b0, addr}, 32'h0);
    doReq(20'h1, 12'h000, 1'b0, c, pa, d, nrd, addr);
    chk("R1 vpn1 over default limit", {30'b0, c}, 32'd1);
    chk("R1 vpn1 no read", nrd, 32'd0);

    // R10 load base (upper bits ignored) and limit
    cfgWrite(1'b0, 32'hFF000100);
    cfgWrite(1'b1, 32'hFFF00014);

    for (int i = 0; i < NV; i++) begin
      mem[VECS[i].vpn[5:0]] = VECS[i].pte;
      doReq(VECS[i].vpn, VECS[i].off, VECS[i].wr, c, pa, d, nrd, addr);
      chk($sformatf("R%0d vec%0d code", VECS[i].req, i), {30'b0, c}, {30'b0, VECS[i].code});
      chk($sformatf("R%0d vec%0d paddr", VECS[i].req, i), {8'b0, pa}, {8'b0, VECS[i].paddr});
      chk($sformatf("R%0d vec%0d dirty", VECS[i].req, i), {31'b0, d}, {31'b0, VECS[i].dirty});
      chk($sformatf("R%0d vec%0d read count", VECS[i].req, i), nrd, VECS[i].rd ? 32'd1 : 32'd0);
      if (VECS[i].rd)
        chk($sformatf("R10 vec%0d entry addr", i), {8'b0, addr},
            32'h100 + {10'b0, VECS[i].vpn, 2'b00});
    end

    // R2 cycle timing of read and response
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {20'h00001, 12'h000}; reqWrite = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R2 read strobe cycle", {31'b0, memRdEn}, 32'd1);
    chk("R2 read address", {8'b0, memAddr}, 32'h104);
    chk("R9 busy after accept", {31'b0, reqReady}, 32'd0);
    @(negedge clk);
    chk("R2 single read", {31'b0, memRdEn}, 32'd0);
    chk("R2 no early response", {31'b0, rspValid}, 32'd0);
    @(negedge clk);
    chk("R2 response cycle", {31'b0, rspValid}, 32'd1);
    chk("R2 response paddr", {8'b0, rspPaddr}, 32'hABC000);
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk("R9 ready after take", {31'b0, reqReady}, 32'd1);

    // R9 back-pressure hold, second request ignored while busy
    @(negedge clk);
    reqValid = 1'b1; reqVaddr = {20'h00002, 12'h456}; reqWrite = 1'b1;
    @(negedge clk);
    reqVaddr = {20'h00003, 12'h000}; reqWrite = 1'b0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      chk("R9 held valid", {31'b0, rspValid}, 32'd1);
      chk("R9 held paddr", {8'b0, rspPaddr}, 32'h123456);
      chk("R9 held code", {30'b0, rspCode}, 32'd0);
      chk("R9 no accept while busy", {31'b0, reqReady}, 32'd0);
      @(negedge clk);
    end
    reqValid = 1'b0;
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk("R9 released", {31'b0, rspValid}, 32'd0);

    // R10 context switch: new base and tighter limit
    cfgWrite(1'b0, 32'h00000200);
    cfgWrite(1'b1, 32'h00000001);
    doReq(20'h1, 12'h0F0, 1'b0, c, pa, d, nrd, addr);
    chk("R10 rebased addr", {8'b0, addr}, 32'h204);
    chk("R10 rebased paddr", {8'b0, pa}, 32'hABC0F0);
    doReq(20'h2, 12'h000, 1'b1, c, pa, d, nrd, addr);
    chk("R10 new limit code", {30'b0, c}, 32'd1);
    chk("R10 new limit no read", nrd, 32'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule